// File: doc/BRIEF.md
# DRAM Strobe-Sequence Cycle Decoder

This block is the device-side control logic of a scaled-down asynchronous DRAM model. A fast sampling clock watches the row strobe, column strobe, write enable and output enable pins. The block works out the kind of each memory cycle from the order in which the strobes change. It then performs that cycle on a small synthesizable cell array. The array has 2^ROW_W rows by 2^COL_W columns by DQ_W bits. At full scale the row and column addresses are each 11 bits wide, giving 2048 rows and 2048 columns.

One rule picks the cycle type. If the column strobe is already low when the row strobe falls, the cycle refreshes the row named by an internal counter, and the counter then advances. If the row strobe falls while the column strobe is high, the row is opened from the address pins, and that activation also refreshes it. Column strobe falls under an open row select a column. Each such fall is either an early write or a read. The read data stays on the pins in the extended-data-out manner.

A sticky protocol flag reports two conditions: a column strobe that falls too soon after the row strobe, and a row strobe held low too long. Every pin is sampled on the clock. A change seen at one rising edge is acted on at that edge, and its result is on the outputs after that edge.

Top module: `dram_strobe_decoder`

## Requirements
- R1: Once the row and column strobes have both been sampled high, the next clock edge leaves `dq_drive` at 0 and `dq_out` at 0.
- R2: A row strobe fall sampled while the column strobe is low is a counter refresh. `rfsh_pulse` is 1 for one cycle, and `rfsh_row` shows the counter value. The counter resets to 0 and then increments modulo 2^ROW_W. The address pins are ignored, no cell is written and the data pins are not driven.
- R3: A row strobe fall sampled while the column strobe is high opens the row `addr[ROW_W-1:0]`. It also pulses `rfsh_pulse` with `rfsh_row` equal to that row. If the column strobe stays high, `dq_drive` stays 0.
- R4: A column strobe fall under an open row with write enable low is an early write. It stores `dq_in` into the cell at (open row, `addr[COL_W-1:0]`), and `dq_drive` is 0 after that edge.
- R5: A column strobe fall under an open row with write enable high is a read. If output enable is low, the cell value is on `dq_out` with `dq_drive` at 1 after that edge. It stays driven after the column strobe rises while the row strobe is low. If output enable is high at that fall, nothing is driven.
- R6: Drive stops at the edge that samples output enable rising. It also stops at the edge that samples write enable falling while the column strobe is high.
- R7: While the row strobe stays low, each new column strobe fall selects a new column of the same open row (page mode), for reads and writes alike.
- R8: If the column strobe stays low after a read while the row strobe rises and falls again, the read data stays driven. Each extra row strobe fall performs a counter refresh as in R2.
- R9: If a column strobe fall under an open row is sampled fewer than RCD_MIN samples after the row strobe fall, `proto_err` is set. It stays set until reset.
- R10: If the row strobe is sampled low for more than RAS_MAX consecutive samples, `proto_err` is set. Exactly RAS_MAX samples do not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_strobe_n | input | 1 | Row strobe, active low |
| col_strobe_n | input | 1 | Column strobe, active low |
| write_en_n | input | 1 | Write enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data from the pins |
| dq_out | output | DQ_W | Read data to the pins (0 when not driven) |
| dq_drive | output | 1 | Tristate enable for the data pins |
| rfsh_pulse | output | 1 | One-cycle pulse per refreshed row |
| rfsh_row | output | ROW_W | Row refreshed by the last pulse |
| proto_err | output | 1 | Sticky protocol violation flag |

## Verification
The embedded properties are checked on every cycle. They cover the following: no drive in standby or after an early write, drive starting only from a qualified read strobe, the refresh counter moving on every counter refresh, and the violation flag holding once set. Data correctness needs the bench's scenarios. This covers page-mode reads of cells written earlier, counter values across successive and hidden refreshes, and the exact sample at which each violation threshold trips. The bench mixes seeded random page traffic checked against a reference array with directed strobe orderings.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;

   // Edge events derived from one sample of the strobe pins
   typedef struct packed {
      logic ras_fall;
      logic ras_rise;
      logic cas_fall;
      logic we_fall;
      logic oe_rise;
   } strobe_ev_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dram_strobe_edges.sv
module dram_strobe_edges
   import dram_dec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ras_n,
   input  logic       cas_n,
   input  logic       we_n,
   input  logic       oe_n,
   output strobe_ev_t ev,
   output logic       ras_q,
   output logic       cas_q
);

   logic we_q, oe_q;

   // Previous samples; strobes idle high out of reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q <= 1'b1;
         cas_q <= 1'b1;
         we_q  <= 1'b1;
         oe_q  <= 1'b1;
      end else begin
         ras_q <= ras_n;
         cas_q <= cas_n;
         we_q  <= we_n;
         oe_q  <= oe_n;
      end
   end

   always_comb begin
      ev.ras_fall = ras_q & ~ras_n;
      ev.ras_rise = ~ras_q & ras_n;
      ev.cas_fall = cas_q & ~cas_n;
      ev.we_fall  = we_q & ~we_n;
      ev.oe_rise  = ~oe_q & oe_n;
   end

endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
   parameter int ROW_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [ROW_W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (adv) cnt <= cnt + 1'b1;
   end

   assert_ctr_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (cnt != $past(cnt)));

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
   parameter int ROW_W = 4,
   parameter int COL_W = 4,
   parameter int DQ_W  = 4
) (
   input  logic             clk,
   input  logic             wr,
   input  logic [ROW_W-1:0] row,
   input  logic [COL_W-1:0] col,
   input  logic [DQ_W-1:0]  wdata,
   output logic [DQ_W-1:0]  rdata
);

   localparam int IDX_W = ROW_W + COL_W;
   localparam int CELLS = 1 << IDX_W;

   logic [IDX_W-1:0] idx;
   assign idx = {row, col};

   // One bit plane per data lane
   for (genvar l = 0; l < DQ_W; l++) begin : g_lane
      logic [CELLS-1:0] plane;
      always_ff @(posedge clk) begin
         if (wr) plane[idx] <= wdata[l];
      end
      assign rdata[l] = plane[idx];
   end

endmodule

// File: rtl/dram_protocol_mon.sv
module dram_protocol_mon #(
   parameter int RAS_MAX = 40,
   parameter int RCD_MIN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ras_n,
   input  logic ras_fall,
   input  logic cas_access,
   output logic err
);

   localparam int CNT_W = $clog2(RAS_MAX + 1) + 1;
   localparam logic [CNT_W-1:0] LIM  = CNT_W'(RAS_MAX);
   localparam logic [CNT_W-1:0] RCD  = CNT_W'(RCD_MIN);

   logic [CNT_W-1:0] low_cnt;
   logic             too_long, too_soon;

   // Count of samples the row strobe has been low, saturating at LIM
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 low_cnt <= '0;
      else if (ras_fall)          low_cnt <= CNT_W'(1);
      else if (ras_n)             low_cnt <= '0;
      else if (low_cnt < LIM)     low_cnt <= low_cnt + 1'b1;
   end

   assign too_long = !ras_n && !ras_fall && (low_cnt >= LIM);
   assign too_soon = cas_access && (low_cnt < RCD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    err <= 1'b0;
      else if (too_long || too_soon) err <= 1'b1;
   end

   assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
   import dram_dec_pkg::*;
#(
   parameter int ROW_W   = 4,
   parameter int COL_W   = 4,
   parameter int DQ_W    = 4,
   parameter int RAS_MAX = 40,
   parameter int RCD_MIN = 2,
   localparam int ADDR_W = max_of(ROW_W, COL_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_strobe_n,
   input  logic              col_strobe_n,
   input  logic              write_en_n,
   input  logic              out_en_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic [DQ_W-1:0]   dq_out,
   output logic              dq_drive,
   output logic              rfsh_pulse,
   output logic [ROW_W-1:0]  rfsh_row,
   output logic              proto_err
);

   // Elaboration-time parameter checks
   if (ROW_W < 1 || ROW_W > 11) begin : g_bad_row
      $error("ROW_W out of range");
   end
   if (COL_W < 1 || COL_W > 11) begin : g_bad_col
      $error("COL_W out of range");
   end
   if (RCD_MIN < 1 || RAS_MAX <= RCD_MIN) begin : g_bad_timing
      $error("timing limits inconsistent");
   end

   strobe_ev_t       ev;
   logic             ras_q, cas_q;
   logic             row_open, rd_valid;
   logic [ROW_W-1:0] row_r, ctr;
   logic [DQ_W-1:0]  dout_r, cell_rd;
   logic             cas_access, cell_wr, cbr_start;

   dram_strobe_edges u_edges (
      .clk(clk), .rst_n(rst_n),
      .ras_n(row_strobe_n), .cas_n(col_strobe_n),
      .we_n(write_en_n), .oe_n(out_en_n),
      .ev(ev), .ras_q(ras_q), .cas_q(cas_q)
   );

   assign cbr_start  = ev.ras_fall && !col_strobe_n;
   assign cas_access = ev.cas_fall && row_open && !row_strobe_n;
   assign cell_wr    = cas_access && !write_en_n;

   dram_refresh_ctr #(.ROW_W(ROW_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .adv(cbr_start), .cnt(ctr)
   );

   dram_cell_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_cells (
      .clk(clk), .wr(cell_wr), .row(row_r), .col(addr[COL_W-1:0]),
      .wdata(dq_in), .rdata(cell_rd)
   );

   dram_protocol_mon #(.RAS_MAX(RAS_MAX), .RCD_MIN(RCD_MIN)) u_mon (
      .clk(clk), .rst_n(rst_n), .ras_n(row_strobe_n),
      .ras_fall(ev.ras_fall), .cas_access(cas_access), .err(proto_err)
   );

   // Row activation and refresh reporting
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_open   <= 1'b0;
         row_r      <= '0;
         rfsh_pulse <= 1'b0;
         rfsh_row   <= '0;
      end else begin
         rfsh_pulse <= 1'b0;
         if (ev.ras_fall) begin
            rfsh_pulse <= 1'b1;
            if (!col_strobe_n) begin
               rfsh_row <= ctr;
            end else begin
               row_open <= 1'b1;
               row_r    <= addr[ROW_W-1:0];
               rfsh_row <= addr[ROW_W-1:0];
            end
         end else if (ev.ras_rise) begin
            row_open <= 1'b0;
         end
      end
   end

   // Extended-data-out output control
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         dout_r   <= '0;
      end else begin
         if (cas_access) begin
            if (!write_en_n) begin
               rd_valid <= 1'b0;
            end else begin
               rd_valid <= !out_en_n;
               dout_r   <= cell_rd;
            end
         end else if ((row_strobe_n && col_strobe_n) || ev.oe_rise ||
                      (ev.we_fall && col_strobe_n)) begin
            rd_valid <= 1'b0;
         end
      end
   end

   assign dq_drive = rd_valid;
   assign dq_out   = rd_valid ? dout_r : '0;

   assert_standby_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_q && cas_q) |-> !dq_drive);

   assert_early_write_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cell_wr |=> !dq_drive);

   assert_drive_from_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_drive) |-> $past(cas_access && write_en_n && !out_en_n));

   assert_rfsh_on_ras_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_pulse |-> $past(ev.ras_fall));

endmodule

// File: tb/tb_dram_strobe_decoder.sv
module tb_dram_strobe_decoder;

   localparam int ROW_W = 4, COL_W = 4, DQ_W = 4, RAS_MAX = 40, RCD_MIN = 2;
   localparam int ADDR_W = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ras_n = 1, cas_n = 1, we_n = 1, oe_n = 1;
   logic [ADDR_W-1:0] addr = '0;
   logic [DQ_W-1:0]   dq_in = '0, dq_out;
   logic dq_drive, rfsh_pulse, proto_err;
   logic [ROW_W-1:0] rfsh_row;

   int checks = 0, failures = 0, cycles = 0;
   logic [DQ_W-1:0] model [0:255];
   logic [ROW_W-1:0] cur_row;
   int exp_ctr = 0;

   always #10 clk = ~clk;

   dram_strobe_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
      .RAS_MAX(RAS_MAX), .RCD_MIN(RCD_MIN)) dut (
      .clk(clk), .rst_n(rst_n), .row_strobe_n(ras_n), .col_strobe_n(cas_n),
      .write_en_n(we_n), .out_en_n(oe_n), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_drive(dq_drive), .rfsh_pulse(rfsh_pulse),
      .rfsh_row(rfsh_row), .proto_err(proto_err));

   function automatic logic [DQ_W-1:0] exp_cell(input logic [ROW_W-1:0] r,
                                                input logic [COL_W-1:0] c);
      return model[{r, c}];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive pins mid-cycle, return just after the sampling edge
   task automatic drive(input logic r, input logic c, input logic w, input logic o,
                        input logic [ADDR_W-1:0] a, input logic [DQ_W-1:0] d);
      @(negedge clk);
      ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a; dq_in = d;
      @(posedge clk);
      #1;
   endtask

   task automatic open_row(input logic [ROW_W-1:0] r);
      cur_row = r;
      drive(0, 1, 1, 1, r, 0);
      chk("R3 pulse", rfsh_pulse, 1);
      chk("R3 row", rfsh_row, r);
      drive(0, 1, 1, 1, r, 0);
      chk("R3 no drive", dq_drive, 0);
   endtask

   task automatic wcol(input logic [COL_W-1:0] c, input logic [DQ_W-1:0] d);
      drive(0, 0, 0, 1, c, d);
      chk("R4 early write hiz", dq_drive, 0);
      model[{cur_row, c}] = d;
      drive(0, 1, 1, 1, c, 0);
   endtask

   task automatic rcol(input logic [COL_W-1:0] c, input string req);
      drive(0, 0, 1, 0, c, 0);
      chk(req, dq_drive, 1);
      chk(req, dq_out, exp_cell(cur_row, c));
      drive(0, 1, 1, 0, c, 0);
      chk("R5 edo hold", dq_drive, 1);
      chk("R5 edo data", dq_out, exp_cell(cur_row, c));
   endtask

   task automatic close_row();
      drive(1, 1, 1, 1, 0, 0);
      chk("R1 standby hiz", dq_drive, 0);
      chk("R1 standby data", dq_out, 0);
   endtask

   task automatic do_reset();
      rst_n = 0;
      drive(1, 1, 1, 1, 0, 0);
      drive(1, 1, 1, 1, 0, 0);
      rst_n = 1;
      drive(1, 1, 1, 1, 0, 0);
      exp_ctr = 0;
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   initial begin : main
      int unsigned seed;
      logic [DQ_W-1:0] keep;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      do_reset();
      chk("R1 reset drive", dq_drive, 0);
      chk("R9 reset err", proto_err, 0);
      chk("R2 reset pulse", rfsh_pulse, 0);

      // Fill the whole array with page-mode writes (R7)
      for (int r = 0; r < 16; r++) begin
         open_row(r[ROW_W-1:0]);
         for (int c = 0; c < 16; c++) wcol(c[COL_W-1:0], 4'(r * 3 + c * 5));
         close_row();
      end

      // Random page traffic
      for (int it = 0; it < 80; it++) begin
         int n;
         open_row(4'($urandom));
         n = 1 + ($urandom % 6);
         for (int k = 0; k < n; k++) begin
            logic [COL_W-1:0] c;
            c = 4'($urandom);
            if ($urandom % 2) wcol(c, 4'($urandom));
            else rcol(c, (k == 0) ? "R5 read" : "R7 page read");
         end
         close_row();
      end
      chk("R9 no false err", proto_err, 0);

      // Read with OE high: nothing driven (R5)
      open_row(4'd3);
      drive(0, 0, 1, 1, 4'd7, 0);
      chk("R5 oe high no drive", dq_drive, 0);
      drive(0, 1, 1, 1, 4'd7, 0);
      // OE rise ends drive (R6)
      rcol(4'd7, "R6 setup read");
      drive(0, 1, 1, 1, 4'd7, 0);
      chk("R6 oe rise", dq_drive, 0);
      // WE pulse while CAS high ends drive (R6)
      rcol(4'd9, "R6 setup read");
      drive(0, 1, 0, 0, 4'd9, 0);
      chk("R6 we pulse", dq_drive, 0);
      drive(0, 1, 1, 0, 4'd9, 0);
      close_row();

      // Counter refresh sequence (R2)
      for (int i = 0; i < 3; i++) begin
         drive(1, 0, 1, 1, 4'hf, 0);
         chk("R2 cas only hiz", dq_drive, 0);
         drive(0, 0, 1, 1, 4'($urandom), 4'($urandom));
         chk("R2 pulse", rfsh_pulse, 1);
         chk("R2 counter row", rfsh_row, exp_ctr[ROW_W-1:0]);
         chk("R2 hiz", dq_drive, 0);
         exp_ctr++;
         drive(0, 0, 1, 1, 0, 0);
         drive(1, 0, 1, 1, 0, 0);
         drive(1, 1, 1, 1, 0, 0);
      end
      // Cells untouched by refresh (R2)
      open_row(4'd0);
      rcol(4'd0, "R2 cell intact");
      rcol(4'd15, "R2 cell intact");
      close_row();

      // Hidden refresh (R8)
      open_row(4'd5);
      keep = exp_cell(4'd5, 4'd2);
      drive(0, 0, 1, 0, 4'd2, 0);
      chk("R8 read", dq_out, keep);
      drive(1, 0, 1, 0, 4'd2, 0);
      chk("R8 hold ras high", dq_drive, 1);
      drive(0, 0, 1, 0, 4'd11, 0);
      chk("R8 refresh pulse", rfsh_pulse, 1);
      chk("R8 refresh row", rfsh_row, exp_ctr[ROW_W-1:0]);
      chk("R8 data kept", dq_out, keep);
      exp_ctr++;
      drive(0, 0, 1, 0, 4'd11, 0);
      drive(1, 0, 1, 0, 0, 0);
      drive(0, 0, 1, 0, 0, 0);
      chk("R8 second refresh", rfsh_row, exp_ctr[ROW_W-1:0]);
      chk("R8 still driven", dq_drive, 1);
      exp_ctr++;
      drive(1, 0, 1, 0, 0, 0);
      drive(1, 1, 1, 0, 0, 0);
      chk("R1 hidden end hiz", dq_drive, 0);

      // RCD violation (R9)
      drive(0, 1, 1, 1, 4'd1, 0);
      drive(0, 0, 1, 0, 4'd1, 0);
      chk("R9 rcd err", proto_err, 1);
      drive(0, 1, 1, 1, 0, 0);
      drive(1, 1, 1, 1, 0, 0);
      chk("R9 sticky", proto_err, 1);
      do_reset();
      chk("R9 cleared by reset", proto_err, 0);

      // RAS low exactly RAS_MAX samples: no error (R10)
      for (int i = 0; i < RAS_MAX; i++) drive(0, 1, 1, 1, 4'd2, 0);
      chk("R10 at limit", proto_err, 0);
      drive(0, 1, 1, 1, 4'd2, 0);
      chk("R10 over limit", proto_err, 1);
      drive(1, 1, 1, 1, 0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule